// File: doc/BRIEF.md
# Serial Bus Transfer Clock Selector

This block turns the internal system clock of a two-wire serial bus controller into the bus transfer rate. A 4-bit selection input `cfg_sel` picks one of a fixed, mode-dependent set of divide ratios. `cfg_sel[3]` is an extension bit, `cfg_sel[2]` chooses high-speed mode (1) or normal mode (0), and `cfg_sel[1:0]` is a rate code. Each legal ratio is the product of a small prescale (divide by 1, 2 or 3) and a fixed inner count. The table below gives only the overall ratio.

While the bus is busy, the block produces a one-cycle `tick` once per selected period. It also produces a serial clock level `scl_en` that is high for the first half of the period and low for the second half. When `bus_idle` is asserted, the divider is held at the start of a period and the clock rests high. The selection is sampled only while the bus is idle, at a period boundary, or while the block is in the error state, so a running period is never cut short. Codes that are not allowed raise `cfg_err` and stop the tick.

Top module: `xfer_clk_sel`

## Requirements
- R1: With `cfg_sel[3:2]`=00 (normal mode), rate codes 00, 01, 10 and 11 give periods of 88, 172, 86 and 198 system clocks.
- R2: With `cfg_sel[3:2]`=01, rate codes 00 and 01 give 48 clocks, 10 gives 24 clocks and 11 gives 54 clocks.
- R3: With `cfg_sel[3:2]`=11, rate codes 00 and 01 give 24 clocks and 10 gives 12 clocks.
- R4: Selections 10xx and 1111 are prohibited. Once such a selection is loaded, `cfg_err` is 1, `tick` stays 0 and `scl_en` stays 1.
- R5: While `cfg_err` is 1, a legal selection is loaded on the next clock edge. That edge clears `cfg_err` and restarts the period at count 0, so the first tick follows D-1 cycles later, and every period after that is D cycles.
- R6: While running with divisor D, `tick` is high for exactly one cycle in every D cycles.
- R7: Within a period, `scl_en` is high for ceil(D/2) cycles and then low for floor(D/2) cycles. The tick falls in the last low cycle.
- R8: A change of `cfg_sel` while the bus is busy leaves the current period at its old length. The new divisor applies from the next period.
- R9: While `bus_idle` is 1, `tick` is 0, `scl_en` is 1 and the counter is held at the period start.
- R10: A synchronous active-high `rst` gives `tick`=0, `scl_en`=1 and `cfg_err`=0, and makes the active divisor 88 (selection 0000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 4 | Extension bit [3], high-speed mode [2], rate code [1:0] |
| bus_idle | input | 1 | Bus idle; holds the divider and allows reconfiguration |
| tick | output | 1 | One-cycle pulse at the end of each transfer period |
| scl_en | output | 1 | Serial clock level, high first half of the period |
| cfg_err | output | 1 | Active selection is prohibited |

## Verification
All sixteen selection codes are loaded in turn while the bus is idle, and the bench then measures the tick spacing and the high-phase length. This separates every entry of the divisor table and catches a swapped rate code or a wrong mode bit. The odd divisors are absent from the table, so the even split is what gets confirmed. The prohibited codes are held for several hundred cycles to show that the tick stays stopped. A legal code is then loaded to show recovery and measure the latency to the first tick. A mid-period change shows that the old period runs to completion, and a reset while running shows that the divisor returns to 88 before the new selection applies at the wrap.

// File: rtl/xfer_clk_sel.sv
module xfer_clk_sel #(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] cfg_sel,
  input  logic       bus_idle,
  output logic       tick,
  output logic       scl_en,
  output logic       cfg_err
);

  logic [DW-1:0] nxt_div, act_div, cnt;
  logic          nxt_bad, act_bad, wrap, load;
  logic [DW:0]   hi_len;

  always_comb begin
    nxt_bad = 1'b0;
    case (cfg_sel)
      4'b0000: nxt_div = DW'(88);
      4'b0001: nxt_div = DW'(172);
      4'b0010: nxt_div = DW'(86);
      4'b0011: nxt_div = DW'(198);
      4'b0100,
      4'b0101: nxt_div = DW'(48);
      4'b0110: nxt_div = DW'(24);
      4'b0111: nxt_div = DW'(54);
      4'b1100,
      4'b1101: nxt_div = DW'(24);
      4'b1110: nxt_div = DW'(12);
      default: begin
        nxt_div = '0;
        nxt_bad = 1'b1;
      end
    endcase
  end

  assign wrap   = !bus_idle && !act_bad && (cnt == act_div - 1'b1);
  assign load   = bus_idle || act_bad || wrap;
  assign hi_len = ({1'b0, act_div} + 1'b1) >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_div <= DW'(88);
      act_bad <= 1'b0;
    end else begin
      if (load) begin
        act_div <= nxt_div;
        act_bad <= nxt_bad;
      end
      cnt <= load ? '0 : cnt + 1'b1;
    end
  end

  assign tick    = wrap;
  assign cfg_err = act_bad;
  assign scl_en  = act_bad || bus_idle || ({1'b0, cnt} < hi_len);

  assert_no_tick_in_err_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!tick && scl_en));

  assert_idle_rest_R9: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> (scl_en && !tick));

  assert_tick_in_low_R7: assert property (@(posedge clk) disable iff (rst)
    tick |-> !scl_en);

  assert_single_tick_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    !act_bad |-> (cnt < act_div));

  assert_hold_div_R8: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle && !cfg_err && !tick) |=> $stable(act_div));

endmodule

// File: tb/xfer_clk_sel_tb_top.sv
module xfer_clk_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg_sel = 4'b0000;
  logic       bus_idle = 1'b1;
  logic       tick, scl_en, cfg_err;
  int         total = 0;
  int         bad = 0;

  always #2 clk = ~clk;

  xfer_clk_sel dut_i (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .bus_idle(bus_idle),
    .tick(tick), .scl_en(scl_en), .cfg_err(cfg_err)
  );

  // {selection, prohibited, divisor}
  localparam logic [12:0] VEC [16] = '{
    {4'b0000, 1'b0, 8'd88},  {4'b0001, 1'b0, 8'd172},
    {4'b0010, 1'b0, 8'd86},  {4'b0011, 1'b0, 8'd198},
    {4'b0100, 1'b0, 8'd48},  {4'b0101, 1'b0, 8'd48},
    {4'b0110, 1'b0, 8'd24},  {4'b0111, 1'b0, 8'd54},
    {4'b1000, 1'b1, 8'd0},   {4'b1001, 1'b1, 8'd0},
    {4'b1010, 1'b1, 8'd0},   {4'b1011, 1'b1, 8'd0},
    {4'b1100, 1'b0, 8'd24},  {4'b1101, 1'b0, 8'd24},
    {4'b1110, 1'b0, 8'd12},  {4'b1111, 1'b1, 8'd0}
  };

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wait_tick();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 1000);
  endtask

  task automatic measure(output int per, output int hi, output int last_scl);
    per = 0;
    hi = 0;
    do begin
      @(negedge clk);
      per++;
      if (scl_en) hi++;
    end while (!tick && per < 1000);
    last_scl = int'(scl_en);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, ls, nt, nl;
    string r;
    repeat (3) @(negedge clk);
    chk("R10 reset tick", int'(tick), 0);
    chk("R10 reset scl_en", int'(scl_en), 1);
    chk("R10 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      int d;
      c = VEC[i][12:9];
      d = int'(VEC[i][7:0]);
      if (VEC[i][8]) r = "R4";
      else if (c[3]) r = "R3";
      else if (c[2]) r = "R2";
      else r = "R1";
      bus_idle = 1'b1;
      cfg_sel = c;
      @(negedge clk);
      @(negedge clk);
      chk({r, " cfg_err"}, int'(cfg_err), int'(VEC[i][8]));
      bus_idle = 1'b0;
      if (VEC[i][8]) begin
        nt = 0; nl = 0;
        for (int k = 0; k < 300; k++) begin
          @(negedge clk);
          if (tick) nt++;
          if (!scl_en) nl++;
        end
        chk({r, " ticks while prohibited"}, nt, 0);
        chk({r, " scl low while prohibited"}, nl, 0);
      end else begin
        wait_tick();
        measure(per, hi, ls);
        chk({r, " period"}, per, d);
        chk("R7 high phase", hi, (d + 1) / 2);
        chk("R7 scl low at tick", ls, 0);
        measure(per, hi, ls);
        chk("R6 repeated period", per, d);
      end
    end

    // recovery from the prohibited 1111 left by the loop
    cfg_sel = 4'b1110;
    @(negedge clk);
    chk("R5 error cleared", int'(cfg_err), 0);
    measure(per, hi, ls);
    chk("R5 first tick latency", per, 11);
    measure(per, hi, ls);
    chk("R5 period after recovery", per, 12);

    // mid-period change
    cfg_sel = 4'b0110;
    wait_tick();
    wait_tick();
    per = 0;
    do begin
      @(negedge clk);
      per++;
      if (per == 5) cfg_sel = 4'b0000;
    end while (!tick && per < 1000);
    chk("R8 current period kept", per, 24);
    measure(per, hi, ls);
    chk("R8 new period applied", per, 88);

    // idle hold
    bus_idle = 1'b1;
    nt = 0; nl = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (tick) nt++;
      if (!scl_en) nl++;
    end
    chk("R9 no tick when idle", nt, 0);
    chk("R9 scl high when idle", nl, 0);
    bus_idle = 1'b0;
    wait_tick();
    measure(per, hi, ls);
    chk("R9 resumes after idle", per, 88);

    // reset while running
    cfg_sel = 4'b1110;
    wait_tick();
    repeat (4) @(negedge clk);
    cfg_sel = 4'b0110;
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset tick running", int'(tick), 0);
    chk("R10 reset scl_en running", int'(scl_en), 1);
    chk("R10 reset cfg_err running", int'(cfg_err), 0);
    rst = 1'b0;
    measure(per, hi, ls);
    chk("R10 divisor after reset", per, 87);
    measure(per, hi, ls);
    chk("R8 selection applied after wrap", per, 24);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule